// File: doc/BRIEF.md
# Debug Core Clock Hold Controller

This block decides whether the processor core is allowed to run. It drives a single core clock-enable output that downstream gating logic uses to stop the core. While that enable is high, the user program runs normally. While it is low, the core is frozen under debugger control, and the debug logic keeps running from its own test clock.

Two sources can ask for a halt. One is the hardware breakpoint signal from a comparator. The other is a software store to a memory-mapped hold register. A halt never cuts an instruction short. A request raised partway through an instruction is parked in a pending state until the core flags the end of that instruction, so the delay from request to halt ranges from one cycle to many.

Only a restart pulse from the debug port releases the core. A 2-bit sticky cause field records which sources caused the halt. A mode output lets the debug port poll whether the core is currently frozen.

Top module: `dbg_clk_hold`

## Requirements
- R1: After reset, core_clk_en is 1, fg_mode is 0 and halt_cause is 2'b00.
- R2: A request that arrives while insn_done is 0 does not stop the core immediately. The core keeps running, with fg_mode at 0, until a cycle in which insn_done is 1. fg_mode then reads 1 from the following cycle on.
- R3: A request sampled in the same cycle as insn_done=1 sets fg_mode to 1 in the very next cycle.
- R4: A write (wr_en=1) to address HOLD_ADDR (default 0x1C) with wr_data bit 0 set to 1 is a software halt request. A write to any other address, or a write with bit 0 equal to 0, has no effect.
- R5: halt_cause bit 0 marks a breakpoint and bit 1 marks a software hold, so 01 means breakpoint only, 10 means software hold only and 11 means both. Requests seen while pending or halted are ORed into the field.
- R6: A restart pulse while halted sets fg_mode to 0 and clears halt_cause to 00 in the next cycle.
- R7: A restart pulse while the core is running or pending has no effect on the mode or on the cause.
- R8: When a halt request and a restart arrive together while halted, the halt request wins. The core stays halted, and halt_cause then holds only the bits of the new request.
- R9: core_clk_en is always the inverse of fg_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_hit | input | 1 | Breakpoint request from the comparator |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW | Bus write address |
| wr_data | input | DW | Bus write data; bit 0 requests a hold |
| insn_done | input | 1 | Asserted on the last cycle of an instruction |
| dp_restart | input | 1 | Restart pulse from the debug port |
| core_clk_en | output | 1 | Core clock enable; 0 holds the core |
| fg_mode | output | 1 | 1 while the core is halted under debugger control |
| halt_cause | output | 2 | Sticky cause: bit 0 breakpoint, bit 1 software hold |

## Verification
Three kinds of events can fall in the same cycle: a halt request and an instruction boundary, a halt request and a restart, and the two halt sources together. The vector walk places each of these pairs in one cycle. It judges the mode and the cause one edge later: the coinciding boundary must halt at once, the restart must lose to the new request and leave only that request's cause bits, and simultaneous sources must show 11. Restarts sent while pending or running, and writes to the wrong address or with bit 0 clear, are checked to leave the outputs unchanged.

// File: rtl/dbg_clk_hold.sv
module dbg_clk_hold #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] HOLD_ADDR = 'h1C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bp_hit,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          insn_done,
  input  logic          dp_restart,
  output logic          core_clk_en,
  output logic          fg_mode,
  output logic [1:0]    halt_cause
);

  typedef enum logic [1:0] {ST_RUN, ST_PEND, ST_HALT} st_t;

  st_t        st, st_n;
  logic [1:0] cause, cause_n;
  logic       sw_req;
  logic [1:0] req;

  assign sw_req = wr_en && (wr_addr == HOLD_ADDR) && wr_data[0];
  assign req    = {sw_req, bp_hit};

  always_comb begin
    st_n    = st;
    cause_n = cause | req;
    case (st)
      ST_RUN:  if (|req) st_n = insn_done ? ST_HALT : ST_PEND;
      ST_PEND: if (insn_done) st_n = ST_HALT;
      ST_HALT: if (dp_restart) begin
        if (|req) cause_n = req;
        else begin
          st_n    = ST_RUN;
          cause_n = 2'b00;
        end
      end
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_RUN;
      cause <= 2'b00;
    end else begin
      st    <= st_n;
      cause <= cause_n;
    end
  end

  assign fg_mode     = (st == ST_HALT);
  assign core_clk_en = !fg_mode;
  assign halt_cause  = cause;

  // R2
  no_early_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fg_mode && !insn_done) |=> !fg_mode);

  // R2
  pend_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PEND && insn_done) |=> fg_mode);

  // R3
  same_cycle_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fg_mode && (bp_hit || sw_req) && insn_done) |=> fg_mode);

  // R5
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fg_mode |-> (halt_cause != 2'b00));

  // R6
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fg_mode && dp_restart && !bp_hit && !sw_req) |=> (!fg_mode && halt_cause == 2'b00));

  // R7
  restart_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fg_mode && dp_restart && !insn_done) |=> !fg_mode);

  // R8
  req_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fg_mode && dp_restart && (bp_hit || sw_req)) |=> fg_mode);

endmodule

// File: tb/dbg_clk_hold_tb.sv
module dbg_clk_hold_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [AW-1:0] HOLD = 'h1C;
  localparam int NV = 17;
  // {bp, sw, done, restart, exp_fg, exp_cause[1:0]}
  localparam logic [6:0] VEC [NV] = '{
    7'b0000_0_00, // idle
    7'b1000_0_01, // R2 bp pending
    7'b0000_0_01, // R2 still running
    7'b0010_1_01, // R2 halt after done
    7'b0000_1_01,
    7'b0001_0_00, // R6
    7'b0110_1_10, // R3 sw + done same cycle
    7'b0001_0_00, // R6
    7'b0001_0_00, // R7 restart while running
    7'b1100_0_11, // R5 both sources
    7'b0011_1_11, // R7 restart in pending ignored, done halts
    7'b1001_1_01, // R8 request wins over restart
    7'b0001_0_00, // R6
    7'b1000_0_01, // R5 pending
    7'b0100_0_11, // R5 accumulate
    7'b0010_1_11,
    7'b0001_0_00  // R6
  };

  logic clk = 0, rst_n = 0;
  logic bp_hit = 0, wr_en = 0, insn_done = 0, dp_restart = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic core_clk_en, fg_mode;
  logic [1:0] halt_cause;
  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_clk_hold #(.AW(AW), .DW(DW), .HOLD_ADDR(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .bp_hit(bp_hit), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .insn_done(insn_done), .dp_restart(dp_restart),
    .core_clk_en(core_clk_en), .fg_mode(fg_mode), .halt_cause(halt_cause));

  task automatic check(input string req, input logic efg, input logic [1:0] ec);
    n_chk++;
    if (fg_mode !== efg || halt_cause !== ec || core_clk_en !== !efg) begin
      n_fail++;
      $display("FAIL %s: fg=%b cause=%b clken=%b expected fg=%b cause=%b clken=%b",
               req, fg_mode, halt_cause, core_clk_en, efg, ec, !efg);
    end
  endtask

  task automatic step(input logic bp, input logic we, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic dn, input logic rs);
    @(negedge clk);
    bp_hit = bp; wr_en = we; wr_addr = a; wr_data = d; insn_done = dn; dp_restart = rs;
    @(posedge clk); #1;
    bp_hit = 0; wr_en = 0; insn_done = 0; dp_restart = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 3000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: expired, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", 1'b0, 2'b00);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5], HOLD, 1, VEC[i][4], VEC[i][3]);
      check($sformatf("R2/R3/R5/R6/R7/R8/R9 vector %0d", i), VEC[i][2], VEC[i][1:0]);
    end
    // R4 wrong address
    step(0, 1, HOLD + 4, 1, 1, 0);
    check("R4 other address", 1'b0, 2'b00);
    // R4 bit 0 clear
    step(0, 1, HOLD, 32'hFFFF_FFFE, 1, 0);
    check("R4 bit0 clear", 1'b0, 2'b00);
    // R4 valid software hold, pending then halt
    step(0, 1, HOLD, 1, 0, 0);
    check("R4 sw pending", 1'b0, 2'b10);
    repeat (5) step(0, 0, 0, 0, 0, 0);
    check("R2 long wait still running", 1'b0, 2'b10);
    step(0, 0, 0, 0, 1, 0);
    check("R2 halt after long wait", 1'b1, 2'b10);
    // R5 breakpoint while halted accumulates
    step(1, 0, 0, 0, 0, 0);
    check("R5 accumulate while halted", 1'b1, 2'b11);
    // R8 sw request with restart
    step(0, 1, HOLD, 1, 0, 1);
    check("R8 sw wins restart", 1'b1, 2'b10);
    // R1 reset while halted
    @(negedge clk); rst_n = 0; #1;
    check("R1 reset while halted", 1'b0, 2'b00);
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, 0, 1);
    check("R7 restart after reset", 1'b0, 2'b00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule